// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block gathers the interrupt requests of a CPU core, picks one winner each time the core is ready, and hands that winner to the core as a 16-bit vector address. Requests come from three kinds of line. There is one external interrupt pin. There is a bank of maskable peripheral lines, each with a local enable. There is a short list of non-maskable lines. The last of the non-maskable lines is the external non-maskable input, and it has a mask of its own.

The core owns two mask bits, I and X, and the block keeps them. Software changes them through a write strobe. Accepting an interrupt sets them through the acknowledge input. A select register lets software lift any one maskable source above all other maskable sources. Software names that source by the low byte of its vector. The external pin can be sensed by level or by falling edge. The winning vector is held with a valid strobe until the core acknowledges it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Maskable source i (0 is the external pin, 1..26 are peripheral lines) has vector low byte 0xF2 - 2*i. When no source is promoted, the lowest active index wins.
- R2: Non-maskable line j (j = 0..2) has vector low byte 0xF8 - 2*j. Non-maskable lines always beat maskable ones, and a lower j always wins.
- R3: The select register holds bits 7:1 of a vector low byte and resets to 0xF2, which selects the external pin. Once 0xDE has been written, source 10 (vector 0xFFDE) beats every other active maskable source.
- R4: A select-register write is ignored while the I mask is 0.
- R5: A software mask write can clear X but can never set it. Writing 1 to X leaves it as it was.
- R6: Reset sets I and X to 1. Acknowledging non-maskable line 2 sets both I and X. Acknowledging any other vector sets I.
- R7: A maskable source is presented only when its local enable is 1 and I is 0. Non-maskable line 2 is presented only when X is 0. Lines 0 and 1 ignore both masks.
- R8: In level mode (edge-select 0), the pin counts as a request only after two consecutive sampled lows. A low that lasts one cycle causes no vector.
- R9: In edge mode (edge-select 1), a falling edge sets a pending flag, and the flag survives the pin going high again. Only an acknowledge of the pin's own vector clears it. Acknowledging any other vector leaves it set.
- R10: The vector output is 0xFF in the high byte and the winner's low byte. Once valid is set, the vector stays unchanged until an acknowledge. Valid then drops for at least one cycle before the next winner appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | 1 | External interrupt pin, active low |
| irq_edge_mode | input | 1 | 0 = level sensing, 1 = falling-edge sensing |
| src_req | input | N_MASK-1 | Peripheral maskable requests, sources 1..N_MASK-1 |
| src_en | input | N_MASK | Local enable for each maskable source, bit 0 is the pin |
| nmi_req | input | N_NMI | Non-maskable requests; the top bit is the X-gated external one |
| mask_wr | input | 1 | Software write strobe for the mask bits |
| mask_wr_x | input | 1 | Value written to X (can only clear) |
| mask_wr_i | input | 1 | Value written to I |
| prio_wr | input | 1 | Write strobe for the select register |
| prio_wdata | input | 7 | Bits 7:1 of the promoted vector low byte |
| ack | input | 1 | Core accepts the presented vector |
| vec_valid | output | 1 | A vector is presented |
| vec_addr | output | 16 | Presented vector address |
| mask_i | output | 1 | Current I mask |
| mask_x | output | 1 | Current X mask |

## Verification
A peripheral or non-maskable request driven before a clock edge is presented at that edge. The external pin passes through two sampling registers, so a pin low appears as a vector on the third edge after it is driven, in either sensing mode. Mask and select writes, and an acknowledge, take effect at their own edge, so a new winner under the new state follows one edge later. The bench drives inputs on the falling clock edge and checks them on the falling edge that comes after the number of rising edges just given. Its checks before the due edge confirm that nothing appears early, and the hold and gap checks confirm the vector does not move during the hold or between two accepts.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;

  // Held winner: presence, kind flags and vector low byte
  typedef struct packed {
    logic       hit;
    logic       xnmi;
    logic       irq;
    logic [7:0] vlow;
  } win_t;

  // Maskable sources step downward from the top vector
  function automatic logic [7:0] mask_vec(input logic [7:0] top, input int idx);
    return 8'(int'(top) - 2 * idx);
  endfunction

  // Non-maskable sources sit above the top vector, highest first
  function automatic logic [7:0] nmi_vec(input logic [7:0] top, input int idx, input int n);
    return 8'(int'(top) + 2 * (n - idx));
  endfunction

endpackage

// File: rtl/irq_pin_cond.sv
`timescale 1ns/1ps
module irq_pin_cond (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr_pend,
  output logic irq_act
);
  logic smp0, smp1, pend;
  logic fall;

  assign fall = smp1 & ~smp0;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp0 <= 1'b1;
      smp1 <= 1'b1;
      pend <= 1'b0;
    end else begin
      smp0 <= pin_n;
      smp1 <= smp0;
      if (!edge_mode)
        pend <= 1'b0;
      else if (fall)
        pend <= 1'b1;
      else if (clr_pend)
        pend <= 1'b0;
    end
  end

  // level: two consecutive low samples; edge: latched pending
  assign irq_act = edge_mode ? pend : (~smp0 & ~smp1);

endmodule

// File: rtl/irq_mask_ctrl.sv
`timescale 1ns/1ps
module irq_mask_ctrl #(
  parameter logic [7:0] VEC_TOP = 8'hF2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_wr,
  input  logic       sw_x,
  input  logic       sw_i,
  input  logic       prio_wr,
  input  logic [7:1] prio_wdata,
  input  logic       accept,
  input  logic       accept_x,
  output logic       mask_i,
  output logic       mask_x,
  output logic [7:1] psel
);
  localparam logic [7:1] PSEL_RST = VEC_TOP[7:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_i <= 1'b1;
      mask_x <= 1'b1;
      psel   <= PSEL_RST;
    end else begin
      if (sw_wr) begin
        mask_i <= sw_i;
        mask_x <= mask_x & sw_x;
      end
      if (accept) begin
        mask_i <= 1'b1;
        if (accept_x)
          mask_x <= 1'b1;
      end
      if (prio_wr && mask_i)
        psel <= prio_wdata;
    end
  end

endmodule

// File: rtl/irq_prio_arb.sv
`timescale 1ns/1ps
module irq_prio_arb
  import irq_prio_pkg::*;
#(
  parameter int         N_MASK  = 27,
  parameter int         N_NMI   = 3,
  parameter logic [7:0] VEC_TOP = 8'hF2
) (
  input  logic [N_MASK-1:0] mreq,
  input  logic [N_MASK-1:0] men,
  input  logic              mask_i,
  input  logic              mask_x,
  input  logic [N_NMI-1:0]  nmi_req,
  input  logic [7:1]        psel,
  output win_t              win
);
  localparam int XNMI = N_NMI - 1;

  logic [N_MASK-1:0] mact;
  int                pdist;
  logic              promo_ok;
  int                promo_idx;

  assign mact = mreq & men & {N_MASK{~mask_i}};

  always_comb begin
    pdist     = int'(VEC_TOP) - int'({psel, 1'b0});
    promo_ok  = (pdist >= 0) && (pdist < 2 * N_MASK);
    promo_idx = pdist / 2;
  end

  always_comb begin
    win = '0;
    // default order: lower index wins (last assignment sticks)
    for (int i = N_MASK - 1; i >= 0; i--) begin
      if (mact[i]) begin
        win.hit  = 1'b1;
        win.irq  = (i == 0);
        win.xnmi = 1'b0;
        win.vlow = mask_vec(VEC_TOP, i);
      end
    end
    // promoted source overrides the default order
    for (int i = 0; i < N_MASK; i++) begin
      if (promo_ok && (i == promo_idx) && mact[i]) begin
        win.hit  = 1'b1;
        win.irq  = (i == 0);
        win.xnmi = 1'b0;
        win.vlow = mask_vec(VEC_TOP, i);
      end
    end
    // non-maskable lines override everything maskable
    for (int j = N_NMI - 1; j >= 0; j--) begin
      if (nmi_req[j] && ((j != XNMI) || !mask_x)) begin
        win.hit  = 1'b1;
        win.irq  = 1'b0;
        win.xnmi = (j == XNMI);
        win.vlow = nmi_vec(VEC_TOP, j, N_NMI);
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int         N_MASK  = 27,
  parameter int         N_NMI   = 3,
  parameter logic [7:0] VEC_TOP = 8'hF2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_pin_n,
  input  logic              irq_edge_mode,
  input  logic [N_MASK-1:1] src_req,
  input  logic [N_MASK-1:0] src_en,
  input  logic [N_NMI-1:0]  nmi_req,
  input  logic              mask_wr,
  input  logic              mask_wr_x,
  input  logic              mask_wr_i,
  input  logic              prio_wr,
  input  logic [7:1]        prio_wdata,
  input  logic              ack,
  output logic              vec_valid,
  output logic [15:0]       vec_addr,
  output logic              mask_i,
  output logic              mask_x
);
  logic       irq_act;
  logic       accept;
  logic [7:1] psel_q;
  win_t       win_c;
  win_t       win_q;
  logic       valid_q;

  assign accept = ack & valid_q;

  irq_pin_cond u_pin (
    .clk       (clk),
    .rst       (rst),
    .pin_n     (irq_pin_n),
    .edge_mode (irq_edge_mode),
    .clr_pend  (accept & win_q.irq),
    .irq_act   (irq_act)
  );

  irq_mask_ctrl #(.VEC_TOP(VEC_TOP)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .sw_wr      (mask_wr),
    .sw_x       (mask_wr_x),
    .sw_i       (mask_wr_i),
    .prio_wr    (prio_wr),
    .prio_wdata (prio_wdata),
    .accept     (accept),
    .accept_x   (win_q.xnmi),
    .mask_i     (mask_i),
    .mask_x     (mask_x),
    .psel       (psel_q)
  );

  irq_prio_arb #(.N_MASK(N_MASK), .N_NMI(N_NMI), .VEC_TOP(VEC_TOP)) u_arb (
    .mreq    ({src_req, irq_act}),
    .men     (src_en),
    .mask_i  (mask_i),
    .mask_x  (mask_x),
    .nmi_req (nmi_req),
    .psel    (psel_q),
    .win     (win_c)
  );

  // presentation register: hold until accepted, then one idle cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      win_q   <= '0;
    end else if (accept) begin
      valid_q <= 1'b0;
    end else if (!valid_q && win_c.hit) begin
      valid_q <= 1'b1;
      win_q   <= win_c;
    end
  end

  assign vec_valid = valid_q;
  assign vec_addr  = {8'hFF, win_q.vlow};

endmodule

// File: rtl/irq_prio_chk.sv
`timescale 1ns/1ps
module irq_prio_chk (
  input logic        clk,
  input logic        rst,
  input logic        ack,
  input logic        vec_valid,
  input logic [15:0] vec_addr,
  input logic        mask_i,
  input logic        mask_x,
  input logic        prio_wr,
  input logic [7:1]  psel
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid && !ack |=> vec_valid && $stable(vec_addr));

  // R10
  vec_page_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> vec_addr[15:8] == 8'hFF);

  // R10
  accept_gap_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid && ack |=> !vec_valid);

  // R5
  x_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mask_x) |-> $past(ack) && $past(vec_valid));

  // R6
  accept_sets_i_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid && ack |=> mask_i);

  // R4
  prio_lock_chk: assert property (@(posedge clk) disable iff (rst)
    prio_wr && !mask_i |=> $stable(psel));

endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ack       (ack),
  .vec_valid (vec_valid),
  .vec_addr  (vec_addr),
  .mask_i    (mask_i),
  .mask_x    (mask_x),
  .prio_wr   (prio_wr),
  .psel      (psel_q)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  localparam int NM = 27;
  localparam int NN = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          irq_pin_n = 1'b1;
  logic          irq_edge_mode = 1'b0;
  logic [NM-1:1] src_req = '0;
  logic [NM-1:0] src_en = '1;
  logic [NN-1:0] nmi_req = '0;
  logic          mask_wr = 1'b0, mask_wr_x = 1'b1, mask_wr_i = 1'b1;
  logic          prio_wr = 1'b0;
  logic [7:1]    prio_wdata = '0;
  logic          ack = 1'b0;
  logic          vec_valid;
  logic [15:0]   vec_addr;
  logic          mask_i, mask_x;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst(rst), .irq_pin_n(irq_pin_n), .irq_edge_mode(irq_edge_mode),
    .src_req(src_req), .src_en(src_en), .nmi_req(nmi_req),
    .mask_wr(mask_wr), .mask_wr_x(mask_wr_x), .mask_wr_i(mask_wr_i),
    .prio_wr(prio_wr), .prio_wdata(prio_wdata), .ack(ack),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .mask_i(mask_i), .mask_x(mask_x)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mask(input logic x, input logic i);
    mask_wr = 1'b1; mask_wr_x = x; mask_wr_i = i;
    tick(1);
    mask_wr = 1'b0;
  endtask

  task automatic write_sel(input logic [7:0] v);
    prio_wr = 1'b1; prio_wdata = v[7:1];
    tick(1);
    prio_wr = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    src_req = '0;
    tick(1);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    tick(1);
    chk("R6 reset valid", vec_valid, 0);
    chk("R6 reset I", mask_i, 1);
    chk("R6 reset X", mask_x, 1);
  endtask

  task automatic t_order();
    src_req[3] = 1; src_req[7] = 1;
    set_mask(1, 0);
    tick(1);
    chk("R1 src3 over src7", {vec_valid, vec_addr}, {1'b1, 16'hFFEC});
    do_ack();
    chk("R10 gap after ack", vec_valid, 0);
    chk("R6 ack sets I", mask_i, 1);
    src_req[26] = 1;
    set_mask(1, 0);
    tick(1);
    chk("R1 last source vector", vec_addr, 16'hFFBE);
    do_ack();
  endtask

  task automatic t_gate();
    src_req[1] = 1; src_en[1] = 0;
    set_mask(1, 0);
    tick(2);
    chk("R7 local enable blocks", vec_valid, 0);
    src_en[1] = 1;
    tick(1);
    chk("R7 enabled source", vec_addr, 16'hFFF0);
    do_ack();
    src_req[1] = 1;
    tick(2);
    chk("R7 I mask blocks", vec_valid, 0);
    src_req = '0;
  endtask

  task automatic t_nmi();
    src_req[1] = 1; nmi_req = 3'b111;
    set_mask(1, 0);
    tick(1);
    chk("R2 nmi0 wins", vec_addr, 16'hFFF8);
    ack = 1; nmi_req[0] = 0; tick(1); ack = 0;
    tick(1);
    chk("R2 nmi1 next", {vec_valid, vec_addr}, {1'b1, 16'hFFF6});
    ack = 1; nmi_req[1] = 0; tick(1); ack = 0;
    tick(1);
    chk("R7 nmi2 blocked by X", vec_valid, 0);
    nmi_req = '0; src_req = '0;
  endtask

  task automatic t_xmask();
    nmi_req[2] = 1;
    set_mask(1, 1);
    chk("R5 X stays 1", mask_x, 1);
    set_mask(0, 1);
    chk("R5 X cleared", mask_x, 0);
    tick(1);
    chk("R7 nmi2 with X clear", vec_addr, 16'hFFF4);
    set_mask(0, 0);
    ack = 1; nmi_req = '0; tick(1); ack = 0;
    chk("R6 nmi2 ack sets X", mask_x, 1);
    chk("R6 nmi2 ack sets I", mask_i, 1);
    set_mask(0, 1);
    set_mask(1, 1);
    chk("R5 software cannot set X", mask_x, 0);
  endtask

  task automatic t_promote();
    src_req[1] = 1; src_req[10] = 1;
    set_mask(0, 0);
    tick(1);
    chk("R3 default promote is pin", vec_addr, 16'hFFF0);
    do_ack();
    write_sel(8'hDE);
    src_req[1] = 1; src_req[10] = 1;
    set_mask(0, 0);
    tick(1);
    chk("R3 DE promotes source 10", vec_addr, 16'hFFDE);
    do_ack();
    set_mask(0, 0);
    write_sel(8'hEE);
    src_req[4] = 1; src_req[10] = 1;
    tick(1);
    chk("R4 write with I=0 ignored", vec_addr, 16'hFFDE);
    do_ack();
    write_sel(8'hF2);
  endtask

  task automatic t_level();
    irq_edge_mode = 0;
    set_mask(0, 0);
    irq_pin_n = 0; tick(1); irq_pin_n = 1;
    tick(3);
    chk("R8 one-cycle low ignored", vec_valid, 0);
    irq_pin_n = 0;
    tick(2);
    chk("R8 not yet after two edges", vec_valid, 0);
    tick(1);
    chk("R8 level request", {vec_valid, vec_addr}, {1'b1, 16'hFFF2});
    irq_pin_n = 1;
    do_ack();
  endtask

  task automatic t_edge();
    irq_edge_mode = 1;
    tick(2);
    irq_pin_n = 0; tick(1); irq_pin_n = 1;
    tick(3);
    chk("R9 pending masked by I", vec_valid, 0);
    nmi_req[0] = 1;
    tick(1);
    chk("R9 nmi served first", vec_addr, 16'hFFF8);
    ack = 1; nmi_req = '0; tick(1); ack = 0;
    set_mask(0, 0);
    tick(1);
    chk("R9 pending kept", {vec_valid, vec_addr}, {1'b1, 16'hFFF2});
    do_ack();
    set_mask(0, 0);
    tick(2);
    chk("R9 pending cleared by ack", vec_valid, 0);
    set_mask(0, 1);
    irq_edge_mode = 0;
  endtask

  task automatic t_hold();
    src_req[5] = 1;
    set_mask(0, 0);
    tick(1);
    chk("R10 presented", vec_addr, 16'hFFE8);
    nmi_req[0] = 1;
    tick(2);
    chk("R10 held until ack", {vec_valid, vec_addr}, {1'b1, 16'hFFE8});
    do_ack();
    chk("R10 idle cycle", vec_valid, 0);
    tick(1);
    chk("R10 next winner", {vec_valid, vec_addr}, {1'b1, 16'hFFF8});
    ack = 1; nmi_req = '0; tick(1); ack = 0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    t_reset();
    t_order();
    t_gate();
    t_nmi();
    t_xmask();
    t_promote();
    t_level();
    t_edge();
    t_hold();
    tick(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule